// File: doc/BRIEF.md
# Tear-Check Read/Write Pointer Tracker

This block keeps a command-mode panel and its frame pusher in step. It runs a virtual read pointer, which is a line counter that follows the panel's scan-out. The counter is reloaded by a frame sync event. That event comes either from a panel tear-effect pin or from an internal vsync strobe. A prescaler divides the line-tick input, and the counter wraps at a programmed height. A write pointer counts the lines actually pushed to the panel.

Each pointer raises a one-cycle interrupt when it lands on a programmed line. A frame-start permit output tells the pusher when it may begin a frame. Before streaming, the read pointer must sit inside a start window just after the programmed start position. While streaming, the write pointer must lead the read pointer by no more than a continue threshold. An auto-refresh unit emits a kick every N selected sync events.

Software configures the block through a flat word-addressed register port with a combinational read path. Command bits seed and recover the write counter.

Top module: `tear_sync_tracker`

## Requirements
- R1: After reset, every counter and configuration register reads zero and all three pulse outputs are low. With start position 0 and start threshold 0, the read line 0 lies inside the window, so `frame_permit` is 1.
- R2: While the counter is enabled, a selected sync event does three things: it loads the read line with the initial value (index 2), increments the 16-bit read frame count, and clears the prescaler. The read status word at index 10 holds the frame count in bits 31:16 and the line in bits 15:0.
- R3: The sync-config word (index 0) holds a divider in bits 15:0. The read line advances once every divider+1 `line_tick` pulses. From the height value (index 1), it steps to 0.
- R4: `rd_irq` pulses for one cycle each time the read line takes the value held at index 3, whether by advance or by reload. It does not repeat while the line holds.
- R5: Bit 20 of sync-config set selects the rising edge of `te_in`, taken after a SYNC_STAGES-flop synchroniser, and `int_vsync` is then ignored. Bit 20 clear selects `int_vsync`, and `te_in` is then ignored. A `te_in` held high gives one event.
- R6: With bit 19 of sync-config clear, the read line, read frame count and prescaler hold against ticks and sync events.
- R7: When a sync event and a line tick fall in the same cycle, the reload wins and the tick is dropped.
- R8: The threshold word (index 6) holds the start threshold in bits 15:0 and the continue threshold in bits 31:16. The start position is at index 5. When not streaming, `frame_permit` is 1 exactly when start ≤ read line ≤ start + start threshold. `frame_req` while permitted enters streaming. Dropping `frame_req` leaves streaming.
- R9: While streaming, `frame_permit` is 1 exactly when 0 ≤ write line − read line ≤ continue threshold.
- R10: Each `wr_line_tick` increments the write line. Each entry into streaming increments the write frame count. Index 7 reads {write frame[31:16], write line[15:0]}. `wr_irq` pulses once when the write line takes the value at index 4.
- R11: A write to index 9 issues commands. Bit 0 seeds the write word to start + start threshold + 1 with the upper half cleared. Bit 1 loads the low half with the start position and keeps the upper half. A direct write to index 7 overrides a same-cycle write tick.
- R12: The auto-refresh word (index 8) has enable in bit 31 and an interval in bits 15:0. With the enable set, `autorefresh_kick` pulses once on every interval-th selected sync event. An interval of 0 gives no kick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Register write index |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read index |
| reg_rdata | output | 32 | Register read data (combinational) |
| te_in | input | 1 | Tear-effect pin from the panel (asynchronous) |
| int_vsync | input | 1 | Internal vsync strobe |
| line_tick | input | 1 | Line-period tick feeding the read-pointer prescaler |
| wr_line_tick | input | 1 | One pulse per line pushed to the panel |
| frame_req | input | 1 | Pusher requests or holds a frame start |
| frame_permit | output | 1 | Frame start or continue is allowed |
| rd_irq | output | 1 | Read-pointer line-match pulse |
| wr_irq | output | 1 | Write-pointer line-match pulse |
| autorefresh_kick | output | 1 | Periodic auto-refresh pulse |

## Verification
Two pairs of functions can collide in the same cycle.

The first pair is a sync reload and a line advance on the read pointer. The bench raises `int_vsync` and `line_tick` in the same cycle. It expects the read status to show the initial line with the frame count stepped by one, and not the advanced line.

The second pair is a register write to the write counter and a write tick. The bench drives both in one cycle and expects the written word back, unchanged by the tick.

A scoreboard queue holds each expected interrupt or kick before the stimulus that should cause it. This also catches repeated or early pulses.

// File: rtl/tst_pkg.sv
package tst_pkg;
   localparam int REG_AW  = 4;
   localparam int WORD_W  = 32;
   localparam int FRAME_W = 16;

   localparam logic [REG_AW-1:0] IX_SYNC    = 4'd0;
   localparam logic [REG_AW-1:0] IX_HEIGHT  = 4'd1;
   localparam logic [REG_AW-1:0] IX_INIT    = 4'd2;
   localparam logic [REG_AW-1:0] IX_RD_IRQ  = 4'd3;
   localparam logic [REG_AW-1:0] IX_WR_IRQ  = 4'd4;
   localparam logic [REG_AW-1:0] IX_START   = 4'd5;
   localparam logic [REG_AW-1:0] IX_THRESH  = 4'd6;
   localparam logic [REG_AW-1:0] IX_WRCNT   = 4'd7;
   localparam logic [REG_AW-1:0] IX_AUTOREF = 4'd8;
   localparam logic [REG_AW-1:0] IX_CMD     = 4'd9;
   localparam logic [REG_AW-1:0] IX_RDSTAT  = 4'd10;

   localparam int BIT_CNT_EN = 19;
   localparam int BIT_EXT    = 20;
   localparam int BIT_AR_EN  = 31;
   localparam int BIT_SEED   = 0;
   localparam int BIT_RECOV  = 1;
endpackage

// File: rtl/tst_vsync_sel.sv
module tst_vsync_sel #(
   parameter int LINE_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_sel,
   input  logic              te_in,
   input  logic              int_vs,
   input  logic              ar_en,
   input  logic [LINE_W-1:0] ar_interval,
   output logic              vs_evt,
   output logic              ar_kick
);
   logic te_s, te_prev;
   logic [LINE_W-1:0] ar_cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign te_s = te_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[SYNC_STAGES-2:0], te_in};
         end
         assign te_s = chain[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) te_prev <= 1'b0;
      else        te_prev <= te_s;
   end

   assign vs_evt = ext_sel ? (te_s & ~te_prev) : int_vs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ar_cnt  <= '0;
         ar_kick <= 1'b0;
      end else begin
         ar_kick <= 1'b0;
         if (!ar_en || ar_interval == '0) begin
            ar_cnt <= '0;
         end else if (vs_evt) begin
            if (ar_cnt + 1'b1 == ar_interval) begin
               ar_cnt  <= '0;
               ar_kick <= 1'b1;
            end else begin
               ar_cnt <= ar_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/tst_rd_ptr.sv
module tst_rd_ptr #(
   parameter int LINE_W  = 16,
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic               vs_evt,
   input  logic               line_tick,
   input  logic [LINE_W-1:0]  div,
   input  logic [LINE_W-1:0]  height,
   input  logic [LINE_W-1:0]  init,
   input  logic [LINE_W-1:0]  irq_line,
   output logic [LINE_W-1:0]  line,
   output logic [FRAME_W-1:0] frame,
   output logic               irq,
   output logic               adv
);
   logic [LINE_W-1:0] pre, nxt;

   assign nxt = (line == height) ? '0 : line + 1'b1;
   assign adv = en && !vs_evt && line_tick && (pre == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line  <= '0;
         frame <= '0;
         pre   <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (en) begin
            if (vs_evt) begin
               line  <= init;
               frame <= frame + 1'b1;
               pre   <= '0;
               irq   <= (init == irq_line);
            end else if (line_tick) begin
               if (pre == div) begin
                  pre  <= '0;
                  line <= nxt;
                  irq  <= (nxt == irq_line);
               end else begin
                  pre <= pre + 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/tst_wr_ptr.sv
module tst_wr_ptr #(
   parameter int LINE_W  = 16,
   parameter int FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [LINE_W-1:0]  load_line,
   input  logic [FRAME_W-1:0] load_frame,
   input  logic               recover,
   input  logic               seed,
   input  logic [LINE_W-1:0]  start_pos,
   input  logic [LINE_W-1:0]  thr_start,
   input  logic               tick,
   input  logic               new_frame,
   input  logic [LINE_W-1:0]  irq_line,
   output logic [LINE_W-1:0]  line,
   output logic [FRAME_W-1:0] frame,
   output logic               irq
);
   logic [LINE_W-1:0] seed_val, inc;

   assign seed_val = start_pos + thr_start + 1'b1;
   assign inc      = line + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line  <= '0;
         frame <= '0;
         irq   <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (load) begin
            line  <= load_line;
            frame <= load_frame;
         end else if (recover) begin
            line <= start_pos;
         end else if (seed) begin
            line  <= seed_val;
            frame <= '0;
         end else begin
            if (tick) begin
               line <= inc;
               irq  <= (inc == irq_line);
            end
            if (new_frame) frame <= frame + 1'b1;
         end
      end
   end
endmodule

// File: rtl/tst_start_gate.sv
module tst_start_gate #(
   parameter int LINE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_req,
   input  logic [LINE_W-1:0] rd_line,
   input  logic [LINE_W-1:0] wr_line,
   input  logic [LINE_W-1:0] start_pos,
   input  logic [LINE_W-1:0] thr_start,
   input  logic [LINE_W-1:0] thr_cont,
   output logic              permit,
   output logic              streaming,
   output logic              grant_new
);
   logic [LINE_W:0] win_hi, lead;
   logic            in_win, in_lead;

   assign win_hi  = {1'b0, start_pos} + {1'b0, thr_start};
   assign in_win  = (rd_line >= start_pos) && ({1'b0, rd_line} <= win_hi);
   assign lead    = {1'b0, wr_line} - {1'b0, rd_line};
   assign in_lead = (wr_line >= rd_line) && (lead <= {1'b0, thr_cont});

   assign permit    = streaming ? in_lead : in_win;
   assign grant_new = frame_req && permit && !streaming;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         streaming <= 1'b0;
      else if (!frame_req) streaming <= 1'b0;
      else if (grant_new)  streaming <= 1'b1;
   end
endmodule

// File: rtl/tear_sync_tracker.sv
module tear_sync_tracker
   import tst_pkg::*;
#(
   parameter int LINE_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_waddr,
   input  logic [31:0]       reg_wdata,
   input  logic [3:0]        reg_raddr,
   output logic [31:0]       reg_rdata,
   input  logic              te_in,
   input  logic              int_vsync,
   input  logic              line_tick,
   input  logic              wr_line_tick,
   input  logic              frame_req,
   output logic              frame_permit,
   output logic              rd_irq,
   output logic              wr_irq,
   output logic              autorefresh_kick
);
   localparam int HALF_W = WORD_W / 2;

   generate
      if (LINE_W < 4 || LINE_W > HALF_W) begin : g_bad_line_w
         $error("LINE_W must lie in 4..16");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic [LINE_W-1:0] cfg_div, cfg_height, cfg_init, cfg_rd_irq, cfg_wr_irq;
   logic [LINE_W-1:0] cfg_start, cfg_thr_start, cfg_thr_cont, cfg_ar_int;
   logic              cfg_cnt_en, cfg_ext, cfg_ar_en;

   logic               vs_evt, rd_adv, streaming, grant_new;
   logic [LINE_W-1:0]  rd_line, wr_line;
   logic [FRAME_W-1:0] rd_frame, wr_frame;
   logic               wr_load, seed_cmd, recover_cmd;

   wire unused_wdata = &{1'b0, reg_wdata};

   function automatic logic [HALF_W-1:0] widen(input logic [LINE_W-1:0] v);
      logic [HALF_W-1:0] r;
      r = '0;
      r[LINE_W-1:0] = v;
      return r;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_div <= '0; cfg_height <= '0; cfg_init <= '0;
         cfg_rd_irq <= '0; cfg_wr_irq <= '0; cfg_start <= '0;
         cfg_thr_start <= '0; cfg_thr_cont <= '0; cfg_ar_int <= '0;
         cfg_cnt_en <= 1'b0; cfg_ext <= 1'b0; cfg_ar_en <= 1'b0;
      end else if (reg_we) begin
         case (reg_waddr)
            IX_SYNC: begin
               cfg_div    <= reg_wdata[LINE_W-1:0];
               cfg_cnt_en <= reg_wdata[BIT_CNT_EN];
               cfg_ext    <= reg_wdata[BIT_EXT];
            end
            IX_HEIGHT: cfg_height <= reg_wdata[LINE_W-1:0];
            IX_INIT:   cfg_init   <= reg_wdata[LINE_W-1:0];
            IX_RD_IRQ: cfg_rd_irq <= reg_wdata[LINE_W-1:0];
            IX_WR_IRQ: cfg_wr_irq <= reg_wdata[LINE_W-1:0];
            IX_START:  cfg_start  <= reg_wdata[LINE_W-1:0];
            IX_THRESH: begin
               cfg_thr_start <= reg_wdata[LINE_W-1:0];
               cfg_thr_cont  <= reg_wdata[HALF_W +: LINE_W];
            end
            IX_AUTOREF: begin
               cfg_ar_int <= reg_wdata[LINE_W-1:0];
               cfg_ar_en  <= reg_wdata[BIT_AR_EN];
            end
            default: ;
         endcase
      end
   end

   assign wr_load     = reg_we && (reg_waddr == IX_WRCNT);
   assign seed_cmd    = reg_we && (reg_waddr == IX_CMD) && reg_wdata[BIT_SEED];
   assign recover_cmd = reg_we && (reg_waddr == IX_CMD) && reg_wdata[BIT_RECOV];

   always_comb begin
      reg_rdata = '0;
      case (reg_raddr)
         IX_SYNC:    reg_rdata = {11'b0, cfg_ext, cfg_cnt_en, 3'b0, widen(cfg_div)};
         IX_HEIGHT:  reg_rdata = {{HALF_W{1'b0}}, widen(cfg_height)};
         IX_INIT:    reg_rdata = {{HALF_W{1'b0}}, widen(cfg_init)};
         IX_RD_IRQ:  reg_rdata = {{HALF_W{1'b0}}, widen(cfg_rd_irq)};
         IX_WR_IRQ:  reg_rdata = {{HALF_W{1'b0}}, widen(cfg_wr_irq)};
         IX_START:   reg_rdata = {{HALF_W{1'b0}}, widen(cfg_start)};
         IX_THRESH:  reg_rdata = {widen(cfg_thr_cont), widen(cfg_thr_start)};
         IX_WRCNT:   reg_rdata = {wr_frame, widen(wr_line)};
         IX_AUTOREF: reg_rdata = {cfg_ar_en, 15'b0, widen(cfg_ar_int)};
         IX_RDSTAT:  reg_rdata = {rd_frame, widen(rd_line)};
         default:    reg_rdata = '0;
      endcase
   end

   tst_vsync_sel #(.LINE_W(LINE_W), .SYNC_STAGES(SYNC_STAGES)) u_vs (
      .clk(clk), .rst_n(rst_n), .ext_sel(cfg_ext), .te_in(te_in),
      .int_vs(int_vsync), .ar_en(cfg_ar_en), .ar_interval(cfg_ar_int),
      .vs_evt(vs_evt), .ar_kick(autorefresh_kick)
   );

   tst_rd_ptr #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .en(cfg_cnt_en), .vs_evt(vs_evt),
      .line_tick(line_tick), .div(cfg_div), .height(cfg_height),
      .init(cfg_init), .irq_line(cfg_rd_irq), .line(rd_line),
      .frame(rd_frame), .irq(rd_irq), .adv(rd_adv)
   );

   tst_wr_ptr #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_wr (
      .clk(clk), .rst_n(rst_n), .load(wr_load),
      .load_line(reg_wdata[LINE_W-1:0]), .load_frame(reg_wdata[WORD_W-1:HALF_W]),
      .recover(recover_cmd), .seed(seed_cmd), .start_pos(cfg_start),
      .thr_start(cfg_thr_start), .tick(wr_line_tick), .new_frame(grant_new),
      .irq_line(cfg_wr_irq), .line(wr_line), .frame(wr_frame), .irq(wr_irq)
   );

   tst_start_gate #(.LINE_W(LINE_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .frame_req(frame_req), .rd_line(rd_line),
      .wr_line(wr_line), .start_pos(cfg_start), .thr_start(cfg_thr_start),
      .thr_cont(cfg_thr_cont), .permit(frame_permit), .streaming(streaming),
      .grant_new(grant_new)
   );
endmodule

// File: rtl/tst_checker.sv
module tst_checker #(
   parameter int LINE_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cnt_en,
   input logic              vs_evt,
   input logic              rd_adv,
   input logic [LINE_W-1:0] rd_line,
   input logic [15:0]       rd_frame,
   input logic [LINE_W-1:0] cfg_init,
   input logic [LINE_W-1:0] cfg_height,
   input logic [LINE_W-1:0] cfg_rd_irq,
   input logic [LINE_W-1:0] cfg_start,
   input logic              rd_irq,
   input logic              frame_req,
   input logic              frame_permit,
   input logic              streaming,
   input logic              recover_cmd,
   input logic              wr_load,
   input logic [LINE_W-1:0] wr_line,
   input logic [15:0]       wr_frame
);
   AST_RELOAD_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && vs_evt) |=> (rd_line == $past(cfg_init))); // R2
   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_adv && rd_line == cfg_height) |=> (rd_line == '0)); // R3
   AST_RD_IRQ_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_irq |-> (rd_line == $past(cfg_rd_irq))); // R4
   AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_en |=> ($stable(rd_line) && $stable(rd_frame))); // R6
   AST_GRANT_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_req && frame_permit && !streaming) |=> streaming); // R8
   AST_RECOVER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (recover_cmd && !wr_load) |=> (wr_line == $past(cfg_start) && $stable(wr_frame))); // R11
endmodule

bind tear_sync_tracker tst_checker #(.LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_en(cfg_cnt_en), .vs_evt(vs_evt),
   .rd_adv(rd_adv), .rd_line(rd_line), .rd_frame(rd_frame),
   .cfg_init(cfg_init), .cfg_height(cfg_height), .cfg_rd_irq(cfg_rd_irq),
   .cfg_start(cfg_start), .rd_irq(rd_irq), .frame_req(frame_req),
   .frame_permit(frame_permit), .streaming(streaming),
   .recover_cmd(recover_cmd), .wr_load(wr_load), .wr_line(wr_line),
   .wr_frame(wr_frame)
);

// File: tb/tb_tear_sync_tracker.sv
`timescale 1ns/1ps
module tb_tear_sync_tracker;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_waddr = '0, reg_raddr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic        te_in = 1'b0, int_vsync = 1'b0, line_tick = 1'b0;
   logic        wr_line_tick = 1'b0, frame_req = 1'b0;
   logic        frame_permit, rd_irq, wr_irq, autorefresh_kick;

   int checks = 0, errors = 0, cycles = 0;
   bit done = 1'b0;
   int exp_q[$];
   localparam int K_RD = 1, K_WR = 2, K_AR = 3;

   always #5 clk = ~clk;

   tear_sync_tracker dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
      .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
      .te_in(te_in), .int_vsync(int_vsync), .line_tick(line_tick),
      .wr_line_tick(wr_line_tick), .frame_req(frame_req),
      .frame_permit(frame_permit), .rd_irq(rd_irq), .wr_irq(wr_irq),
      .autorefresh_kick(autorefresh_kick)
   );

   task automatic check(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic void match(input int kind);
      checks++;
      if (exp_q.size() == 0) begin
         errors++;
         $display("FAIL R4/R10/R12 pulse: got kind %0d expected none", kind);
      end else begin
         int e = exp_q.pop_front();
         if (e != kind) begin
            errors++;
            $display("FAIL R4/R10/R12 pulse: got kind %0d expected %0d", kind, e);
         end
      end
   endfunction

   // scoreboard monitor
   always @(negedge clk) if (rst_n) begin
      if (rd_irq)           match(K_RD);
      if (wr_irq)           match(K_WR);
      if (autorefresh_kick) match(K_AR);
   end

   task automatic wreg(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rreg(input logic [3:0] a, output logic [31:0] d);
      reg_raddr = a; #1; d = reg_rdata;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); line_tick = 1'b1;
         @(negedge clk); line_tick = 1'b0;
      end
   endtask

   task automatic wticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); wr_line_tick = 1'b1;
         @(negedge clk); wr_line_tick = 1'b0;
      end
   endtask

   task automatic ivs();
      @(negedge clk); int_vsync = 1'b1;
      @(negedge clk); int_vsync = 1'b0;
   endtask

   task automatic te_pulse();
      @(negedge clk); te_in = 1'b1;
      repeat (6) @(negedge clk);
      te_in = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
         finish_run();
      end
   end

   logic [31:0] d;
   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rreg(4'd10, d); check("R1 rd status", d, 0);
      rreg(4'd7, d);  check("R1 wr word", d, 0);
      rreg(4'd0, d);  check("R1 sync cfg", d, 0);
      check("R1 permit", frame_permit, 1);
      check("R1 irqs", {rd_irq, wr_irq, autorefresh_kick}, 0);

      wreg(4'd0, (32'd1 << 19) | 32'd1);
      wreg(4'd1, 9); wreg(4'd2, 2); wreg(4'd3, 5); wreg(4'd4, 9);
      wreg(4'd5, 4); wreg(4'd6, (32'd3 << 16) | 32'd2);
      rreg(4'd6, d); check("R8 thresh readback", d, 32'h0003_0002);

      ivs();
      rreg(4'd10, d); check("R2 reload", d, 32'h0001_0002);
      ticks(1); rreg(4'd10, d); check("R3 prescale hold", d, 32'h0001_0002);
      ticks(1); rreg(4'd10, d); check("R3 advance", d, 32'h0001_0003);
      exp_q.push_back(K_RD);
      ticks(4); rreg(4'd10, d); check("R4 line 5", d, 32'h0001_0005);
      ticks(8); rreg(4'd10, d); check("R3 at height", d, 32'h0001_0009);
      ticks(2); rreg(4'd10, d); check("R3 wrap", d, 32'h0001_0000);
      check("R8 outside window", frame_permit, 0);
      ticks(8);
      check("R8 inside window", frame_permit, 1);

      wreg(4'd9, 32'h1);
      rreg(4'd7, d); check("R11 seed", d, 32'h0000_0007);
      @(negedge clk); frame_req = 1'b1;
      @(negedge clk);
      rreg(4'd7, d); check("R10 frame count", d, 32'h0001_0007);
      check("R9 lead 3", frame_permit, 1);
      exp_q.push_back(K_RD);
      ticks(2);
      exp_q.push_back(K_WR);
      wticks(2);
      rreg(4'd7, d); check("R10 wr line", d, 32'h0001_0009);
      check("R9 lead 4 over", frame_permit, 0);
      ticks(2);
      check("R9 lead 3 again", frame_permit, 1);
      wreg(4'd9, 32'h2);
      rreg(4'd7, d); check("R11 recover", d, 32'h0001_0004);
      check("R9 write behind", frame_permit, 0);
      @(negedge clk); frame_req = 1'b0;
      @(negedge clk);
      check("R8 stream ends", frame_permit, 1);

      // R7 collision
      @(negedge clk); int_vsync = 1'b1; line_tick = 1'b1;
      @(negedge clk); int_vsync = 1'b0; line_tick = 1'b0;
      rreg(4'd10, d); check("R7 reload wins", d, 32'h0002_0002);
      // R11 write vs tick
      @(negedge clk); reg_we = 1'b1; reg_waddr = 4'd7; reg_wdata = 32'h0003_0010; wr_line_tick = 1'b1;
      @(negedge clk); reg_we = 1'b0; wr_line_tick = 1'b0;
      rreg(4'd7, d); check("R11 write wins", d, 32'h0003_0010);

      // R5 source select
      wreg(4'd0, (32'd1 << 20) | (32'd1 << 19) | 32'd1);
      ivs();
      rreg(4'd10, d); check("R5 int ignored", d, 32'h0002_0002);
      @(negedge clk); te_in = 1'b1;
      repeat (6) @(negedge clk);
      rreg(4'd10, d); check("R5 te edge", d, 32'h0003_0002);
      repeat (4) @(negedge clk);
      rreg(4'd10, d); check("R5 te level once", d, 32'h0003_0002);
      te_in = 1'b0; repeat (4) @(negedge clk);

      // R6 disabled
      wreg(4'd0, (32'd1 << 20) | 32'd1);
      ticks(2); te_pulse();
      rreg(4'd10, d); check("R6 hold", d, 32'h0003_0002);

      // R12 auto-refresh
      wreg(4'd8, (32'd1 << 31) | 32'd2);
      rreg(4'd8, d); check("R12 readback", d, 32'h8000_0002);
      te_pulse();
      exp_q.push_back(K_AR);
      te_pulse();
      repeat (3) @(negedge clk);
      check("R4 R10 R12 queue drained", exp_q.size(), 0);
      finish_run();
   end
endmodule